// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired sequencer that steers a multicycle 32-bit processor datapath. A small instruction set is supported: register-register operations, word load, word store, branch on equal, OR with immediate and unconditional jump. Every instruction starts with a fetch step and a decode step. It then runs one to three further steps, depending on its opcode, and returns to fetch.

The controller holds a 4-bit step number from 0 to 11. An explicit next-step function computes the following step from the current step and the 6-bit opcode. Each step has one fixed pattern of datapath controls: write enables, multiplexer selects and an ALU operation code. These controls are registered. The registers load the pattern of the step being entered, so the controls change on the same clock edge as the step number and carry no combinational path from the opcode.

Control fields that the datapath ignores in a given step are driven to 0, so every output is fully defined in every step.

Top module: `mcyc_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the step becomes 0 at that edge and the outputs carry the step-0 pattern.
- R2: Step 0 (fetch) drives pc_wr=1, ir_wr=1, alu_op=00 (add), alu_sel_a=0, alu_sel_b=00, iord=0 and pc_src=00, and always moves to step 1.
- R3: Step 1 (decode) drives br_wr=1, ext_op=1, alu_sel_b=10 and alu_op=00. It moves to step 6 for opcode 000000 (register op), 9 for 000010 (jump), 8 for 000100 (branch), 10 for 001011 (OR immediate), and 2 for 100011 (load) or 101011 (store).
- R4: In step 1, any opcode not listed in R3 sends the controller back to step 0.
- R5: Step 2 (address) drives alu_sel_a=1, alu_sel_b=11, ext_op=1 and alu_op=00. It moves to step 3 for opcode 100011, to step 5 for 101011, and to step 0 for any other opcode.
- R6: Load path: step 3 drives iord=1, alu_sel_a=1, alu_sel_b=11 and ext_op=1, then moves to step 4. Step 4 drives reg_wr=1, memto_reg=1, alu_sel_a=1, alu_sel_b=11 and ext_op=1, then moves to step 0.
- R7: Step 5 (store) drives mem_wr=1, iord=1, alu_sel_a=1, alu_sel_b=11 and ext_op=1, then moves to step 0.
- R8: Register-op path: step 6 drives reg_dst=1, alu_sel_a=1, alu_sel_b=01 and alu_op=11, then moves to step 7. Step 7 repeats that pattern with reg_wr=1 and memto_reg=0, then moves to step 0.
- R9: Step 8 (branch) drives pc_wr_cond=1, pc_src=01, alu_op=01 (subtract), alu_sel_a=1 and alu_sel_b=01, then moves to step 0.
- R10: Step 9 (jump) drives pc_wr=1 and pc_src=10 (jump target), then moves to step 0.
- R11: OR-immediate path: steps 10 and 11 both drive alu_op=10 (OR), alu_sel_a=1 and alu_sel_b=11, with ext_op=0. Step 11 adds reg_wr=1. Step 10 moves to 11, and 11 moves to 0.
- R12: Any enable or select not named for a step in R2 to R11 is 0 in that step.
- R13: The controls of a step appear in the same cycle as its step number on `state_o`. They do not lag it by a cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode of the instruction in flight |
| state_o | output | 4 | Current step number |
| pc_wr | output | 1 | Unconditional program counter write |
| pc_wr_cond | output | 1 | Program counter write when ALU result is zero |
| ir_wr | output | 1 | Instruction register load |
| mem_wr | output | 1 | Memory write |
| reg_wr | output | 1 | Register file write |
| br_wr | output | 1 | Branch target register load |
| iord | output | 1 | Memory address from ALU result (1) or PC (0) |
| reg_dst | output | 1 | Destination register from rd field (1) or rt (0) |
| memto_reg | output | 1 | Register write data from memory (1) or ALU (0) |
| ext_op | output | 1 | Sign-extend (1) or zero-extend (0) the immediate |
| alu_sel_a | output | 1 | ALU A operand: register (1) or PC (0) |
| alu_sel_b | output | 2 | ALU B operand: 00 four, 01 register, 10 shifted immediate, 11 immediate |
| pc_src | output | 2 | PC source: 00 ALU, 01 branch target, 10 jump target |
| alu_op | output | 2 | 00 add, 01 subtract, 10 OR, 11 function-field |

## Verification
The bench targets the two fan-out points. Every valid opcode is checked at decode, and the load and store split is checked at the address step. A swapped dispatch entry would send an instruction into another instruction's path, and the full compare of the control word would show this at once. Opcodes one bit away from valid ones are sent into decode; a decoder that ignored a bit would start a path instead of going back to fetch. Resets applied in the middle of an instruction catch a controller that finishes the instruction first. Checking the controls in the first cycle of each step catches outputs registered from the current step, which would show the previous step's pattern.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
  localparam int OPC_W = 6;
  localparam int STEP_W = 4;

  localparam logic [OPC_W-1:0] OP_RTYPE = 6'b000000;
  localparam logic [OPC_W-1:0] OP_JUMP  = 6'b000010;
  localparam logic [OPC_W-1:0] OP_BRANCH = 6'b000100;
  localparam logic [OPC_W-1:0] OP_ORIMM = 6'b001011;
  localparam logic [OPC_W-1:0] OP_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OP_STORE = 6'b101011;

  typedef enum logic [STEP_W-1:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_ADDR   = 4'd2,
    ST_LDMEM  = 4'd3,
    ST_LDWB   = 4'd4,
    ST_STMEM  = 4'd5,
    ST_REXE   = 4'd6,
    ST_RWB    = 4'd7,
    ST_BRANCH = 4'd8,
    ST_JUMP   = 4'd9,
    ST_OREXE  = 4'd10,
    ST_ORWB   = 4'd11
  } step_e;

  typedef enum logic [2:0] {
    CL_RTYPE, CL_LOAD, CL_STORE, CL_BRANCH, CL_ORIMM, CL_JUMP, CL_BAD
  } opclass_e;

  typedef enum logic [1:0] {
    AOP_ADD = 2'b00, AOP_SUB = 2'b01, AOP_OR = 2'b10, AOP_FUNC = 2'b11
  } aluop_e;

  typedef enum logic [1:0] {
    PCS_ALU = 2'b00, PCS_BRT = 2'b01, PCS_JMP = 2'b10
  } pcsrc_e;

  typedef struct packed {
    logic       pc_wr;
    logic       pc_wr_cond;
    logic       ir_wr;
    logic       mem_wr;
    logic       reg_wr;
    logic       br_wr;
    logic       iord;
    logic       reg_dst;
    logic       memto_reg;
    logic       ext_op;
    logic       alu_sel_a;
    logic [1:0] alu_sel_b;
    pcsrc_e     pc_src;
    aluop_e     alu_op;
  } ctl_t;
endpackage

// File: rtl/mcyc_opdec.sv
module mcyc_opdec
  import mcyc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output opclass_e         cls
);
  always_comb begin
    unique case (opcode)
      OP_RTYPE:  cls = CL_RTYPE;
      OP_LOAD:   cls = CL_LOAD;
      OP_STORE:  cls = CL_STORE;
      OP_BRANCH: cls = CL_BRANCH;
      OP_ORIMM:  cls = CL_ORIMM;
      OP_JUMP:   cls = CL_JUMP;
      default:   cls = CL_BAD;
    endcase
  end
endmodule

// File: rtl/mcyc_nextstep.sv
module mcyc_nextstep
  import mcyc_pkg::*;
(
  input  step_e    step,
  input  opclass_e cls,
  output step_e    step_next
);
  always_comb begin
    step_next = ST_FETCH;
    case (step)
      ST_FETCH: step_next = ST_DECODE;
      ST_DECODE: begin
        case (cls)
          CL_RTYPE:          step_next = ST_REXE;
          CL_JUMP:           step_next = ST_JUMP;
          CL_BRANCH:         step_next = ST_BRANCH;
          CL_ORIMM:          step_next = ST_OREXE;
          CL_LOAD, CL_STORE: step_next = ST_ADDR;
          default:           step_next = ST_FETCH;
        endcase
      end
      ST_ADDR: begin
        if (cls == CL_LOAD)       step_next = ST_LDMEM;
        else if (cls == CL_STORE) step_next = ST_STMEM;
        else                      step_next = ST_FETCH;
      end
      ST_LDMEM: step_next = ST_LDWB;
      ST_REXE:  step_next = ST_RWB;
      ST_OREXE: step_next = ST_ORWB;
      default:  step_next = ST_FETCH;
    endcase
  end
endmodule

// File: rtl/mcyc_ctlrom.sv
module mcyc_ctlrom
  import mcyc_pkg::*;
(
  input  step_e step,
  output ctl_t  word
);
  always_comb begin
    word = '0;
    case (step)
      ST_FETCH: begin
        word.pc_wr = 1'b1;
        word.ir_wr = 1'b1;
      end
      ST_DECODE: begin
        word.br_wr     = 1'b1;
        word.ext_op    = 1'b1;
        word.alu_sel_b = 2'b10;
      end
      ST_ADDR: begin
        word.alu_sel_a = 1'b1;
        word.alu_sel_b = 2'b11;
        word.ext_op    = 1'b1;
      end
      ST_LDMEM: begin
        word.iord      = 1'b1;
        word.alu_sel_a = 1'b1;
        word.alu_sel_b = 2'b11;
        word.ext_op    = 1'b1;
      end
      ST_LDWB: begin
        word.reg_wr    = 1'b1;
        word.memto_reg = 1'b1;
        word.alu_sel_a = 1'b1;
        word.alu_sel_b = 2'b11;
        word.ext_op    = 1'b1;
      end
      ST_STMEM: begin
        word.mem_wr    = 1'b1;
        word.iord      = 1'b1;
        word.alu_sel_a = 1'b1;
        word.alu_sel_b = 2'b11;
        word.ext_op    = 1'b1;
      end
      ST_REXE, ST_RWB: begin
        word.reg_dst   = 1'b1;
        word.alu_sel_a = 1'b1;
        word.alu_sel_b = 2'b01;
        word.alu_op    = AOP_FUNC;
        word.reg_wr    = (step == ST_RWB);
      end
      ST_BRANCH: begin
        word.pc_wr_cond = 1'b1;
        word.pc_src     = PCS_BRT;
        word.alu_op     = AOP_SUB;
        word.alu_sel_a  = 1'b1;
        word.alu_sel_b  = 2'b01;
      end
      ST_JUMP: begin
        word.pc_wr  = 1'b1;
        word.pc_src = PCS_JMP;
      end
      ST_OREXE, ST_ORWB: begin
        word.alu_op    = AOP_OR;
        word.alu_sel_a = 1'b1;
        word.alu_sel_b = 2'b11;
        word.reg_wr    = (step == ST_ORWB);
      end
      default: word = '0;
    endcase
  end
endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcyc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OPC_W-1:0] opcode,
  output logic [STEP_W-1:0] state_o,
  output logic             pc_wr,
  output logic             pc_wr_cond,
  output logic             ir_wr,
  output logic             mem_wr,
  output logic             reg_wr,
  output logic             br_wr,
  output logic             iord,
  output logic             reg_dst,
  output logic             memto_reg,
  output logic             ext_op,
  output logic             alu_sel_a,
  output logic [1:0]       alu_sel_b,
  output logic [1:0]       pc_src,
  output logic [1:0]       alu_op
);
  step_e    step_q, step_n, step_load;
  opclass_e cls;
  ctl_t     word_n, ctl_q;

  mcyc_opdec u_dec (.opcode(opcode), .cls(cls));
  mcyc_nextstep u_ns (.step(step_q), .cls(cls), .step_next(step_n));

  // Controls are looked up for the step being entered (R13).
  assign step_load = rst ? ST_FETCH : step_n;
  mcyc_ctlrom u_rom (.step(step_load), .word(word_n));

  always_ff @(posedge clk) begin
    step_q <= step_load;
    ctl_q  <= word_n;
  end

  assign state_o    = step_q;
  assign pc_wr      = ctl_q.pc_wr;
  assign pc_wr_cond = ctl_q.pc_wr_cond;
  assign ir_wr      = ctl_q.ir_wr;
  assign mem_wr     = ctl_q.mem_wr;
  assign reg_wr     = ctl_q.reg_wr;
  assign br_wr      = ctl_q.br_wr;
  assign iord       = ctl_q.iord;
  assign reg_dst    = ctl_q.reg_dst;
  assign memto_reg  = ctl_q.memto_reg;
  assign ext_op     = ctl_q.ext_op;
  assign alu_sel_a  = ctl_q.alu_sel_a;
  assign alu_sel_b  = ctl_q.alu_sel_b;
  assign pc_src     = ctl_q.pc_src;
  assign alu_op     = ctl_q.alu_op;
endmodule

// File: rtl/mcyc_ctrl_chk.sv
module mcyc_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [5:0] opcode,
  input logic [3:0] state_o,
  input logic       pc_wr,
  input logic       pc_wr_cond,
  input logic       ir_wr,
  input logic       mem_wr,
  input logic       reg_wr,
  input logic       br_wr,
  input logic       iord,
  input logic [1:0] pc_src
);
  logic op_known;
  assign op_known = (opcode == 6'b000000) || (opcode == 6'b000010) ||
                    (opcode == 6'b000100) || (opcode == 6'b001011) ||
                    (opcode == 6'b100011) || (opcode == 6'b101011);

  a_r1_reset_to_fetch: assert property (@(posedge clk) rst |=> state_o == 4'd0);

  a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
    (state_o == 4'd0) |=> (state_o == 4'd1));

  a_r2_fetch_loads_ir: assert property (@(posedge clk) disable iff (rst)
    (state_o == 4'd0) |-> (pc_wr && ir_wr && !mem_wr && !reg_wr));

  a_r4_unknown_back: assert property (@(posedge clk) disable iff (rst)
    (state_o == 4'd1 && !op_known) |=> (state_o == 4'd0));

  a_r5_load_split: assert property (@(posedge clk) disable iff (rst)
    (state_o == 4'd2 && opcode == 6'b100011) |=> (state_o == 4'd3));

  a_r7_store_only: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (state_o == 4'd5 && iord));

  a_r9_cond_write: assert property (@(posedge clk) disable iff (rst)
    pc_wr_cond |-> (state_o == 4'd8 && pc_src == 2'b01));

  a_r12_one_store: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_wr, reg_wr, br_wr}));

  a_r12_step_range: assert property (@(posedge clk) disable iff (rst)
    state_o <= 4'd11);
endmodule

bind mcyc_ctrl mcyc_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .opcode(opcode), .state_o(state_o),
  .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .ir_wr(ir_wr), .mem_wr(mem_wr),
  .reg_wr(reg_wr), .br_wr(br_wr), .iord(iord), .pc_src(pc_src)
);

// File: tb/mcyc_ctrl_bench.sv
module mcyc_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int RUN_CYCLES = 4000;

  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] opcode;
  logic [3:0] state_o;
  logic       pc_wr, pc_wr_cond, ir_wr, mem_wr, reg_wr, br_wr;
  logic       iord, reg_dst, memto_reg, ext_op, alu_sel_a;
  logic [1:0] alu_sel_b, pc_src, alu_op;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcyc_ctrl u_mcyc_ctrl (
    .clk(clk), .rst(rst), .opcode(opcode), .state_o(state_o),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .ir_wr(ir_wr), .mem_wr(mem_wr),
    .reg_wr(reg_wr), .br_wr(br_wr), .iord(iord), .reg_dst(reg_dst),
    .memto_reg(memto_reg), .ext_op(ext_op), .alu_sel_a(alu_sel_a),
    .alu_sel_b(alu_sel_b), .pc_src(pc_src), .alu_op(alu_op)
  );

  function automatic bit is_known(input logic [5:0] op);
    return op == 6'b000000 || op == 6'b000010 || op == 6'b000100 ||
           op == 6'b001011 || op == 6'b100011 || op == 6'b101011;
  endfunction

  // Next step, from R2..R11 and R4.
  function automatic logic [3:0] step_after(input logic [3:0] s, input logic [5:0] op);
    case (s)
      4'd0: return 4'd1;
      4'd1: case (op)
              6'b000000: return 4'd6;
              6'b000010: return 4'd9;
              6'b000100: return 4'd8;
              6'b001011: return 4'd10;
              6'b100011, 6'b101011: return 4'd2;
              default: return 4'd0;
            endcase
      4'd2: return (op == 6'b100011) ? 4'd3 : (op == 6'b101011) ? 4'd5 : 4'd0;
      4'd3: return 4'd4;
      4'd6: return 4'd7;
      4'd10: return 4'd11;
      default: return 4'd0;
    endcase
  endfunction

  // Expected word: pc_wr,pc_wr_cond,ir_wr,mem_wr,reg_wr,br_wr,iord,reg_dst,
  // memto_reg,ext_op,alu_sel_a | alu_sel_b | pc_src | alu_op (R12: rest 0).
  function automatic logic [16:0] word_for(input logic [3:0] s);
    case (s)
      4'd0:  return {11'b10100000000, 2'b00, 2'b00, 2'b00};
      4'd1:  return {11'b00000100010, 2'b10, 2'b00, 2'b00};
      4'd2:  return {11'b00000000011, 2'b11, 2'b00, 2'b00};
      4'd3:  return {11'b00000010011, 2'b11, 2'b00, 2'b00};
      4'd4:  return {11'b00001000111, 2'b11, 2'b00, 2'b00};
      4'd5:  return {11'b00010010011, 2'b11, 2'b00, 2'b00};
      4'd6:  return {11'b00000001001, 2'b01, 2'b00, 2'b11};
      4'd7:  return {11'b00001001001, 2'b01, 2'b00, 2'b11};
      4'd8:  return {11'b01000000001, 2'b01, 2'b01, 2'b01};
      4'd9:  return {11'b10000000000, 2'b00, 2'b10, 2'b00};
      4'd10: return {11'b00000000001, 2'b11, 2'b00, 2'b10};
      4'd11: return {11'b00001000001, 2'b11, 2'b00, 2'b10};
      default: return '0;
    endcase
  endfunction

  function automatic string tag_for(input logic [3:0] s);
    case (s)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2: return "R5";
      4'd3, 4'd4: return "R6";
      4'd5: return "R7";
      4'd6, 4'd7: return "R8";
      4'd8: return "R9";
      4'd9: return "R10";
      default: return "R11";
    endcase
  endfunction

  logic [16:0] got_word;
  assign got_word = {pc_wr, pc_wr_cond, ir_wr, mem_wr, reg_wr, br_wr, iord,
                     reg_dst, memto_reg, ext_op, alu_sel_a, alu_sel_b, pc_src, alu_op};

  // Both step and controls are compared in the first cycle of a step (R12, R13).
  task automatic check(input logic [3:0] exp_s, input string tag);
    n_tests++;
    if (state_o !== exp_s || got_word !== word_for(exp_s)) begin
      n_fail++;
      $display("FAIL %s (R12 R13): step=%0d word=%h expected step=%0d word=%h",
               tag, state_o, got_word, exp_s, word_for(exp_s));
    end
  endtask

  logic [5:0] directed [0:9];
  initial begin
    directed[0] = 6'b100011; directed[1] = 6'b101011; directed[2] = 6'b000000;
    directed[3] = 6'b000100; directed[4] = 6'b001011; directed[5] = 6'b000010;
    directed[6] = 6'b100111; directed[7] = 6'b001010; directed[8] = 6'b111111;
    directed[9] = 6'b000001;
  end

  initial begin
    logic [3:0] exp_s;
    string      tag;
    bit         started;
    int         dir_i;
    int         seed;
    exp_s = 4'd0; tag = "R1"; started = 1'b0; dir_i = 0; seed = 0;
    void'($urandom(32'h5eed_0361));
    rst = 1'b1; opcode = 6'b000000;
    for (int cyc = 0; cyc < RUN_CYCLES; cyc++) begin
      @(negedge clk);
      if (started) check(exp_s, tag);
      // new inputs
      rst = (cyc < 2) || (cyc == 200) || (cyc == 203) || ($urandom_range(0, 79) == 0);
      if (exp_s == 4'd0) begin
        if (dir_i < 10) begin
          opcode = directed[dir_i];
          dir_i++;
        end else begin
          seed = $urandom_range(0, 9);
          opcode = (seed < 8) ? directed[seed % 6] : 6'($urandom);
        end
      end
      if (rst) tag = "R1";
      else if (exp_s == 4'd1 && !is_known(opcode)) tag = "R4";
      else tag = tag_for(step_after(exp_s, opcode));
      exp_s = rst ? 4'd0 : step_after(exp_s, opcode);
      started = 1'b1;
    end
    @(negedge clk);
    check(exp_s, tag);
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, expected end within limit");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule